// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings an asynchronous EDO DRAM with a 9-bit multiplexed address out of power-up and then keeps its contents alive. Once reset is released it stays silent for a programmed settling pause. It then runs a fixed number of wake-up refresh cycles and raises `init_done`. After that it owes the memory one refresh per interval, where the interval is the retention period divided by the number of rows. Every interval is derived from the clock frequency parameter, so the same source serves any clock rate.

The block shares the memory pins with other masters. Whenever it owes refresh work it raises `bus_req` and waits for `bus_gnt`. If the grant is late, the intervals it misses are counted up to a cap, and the whole debt is paid as one back-to-back burst once the bus is granted. Each refresh cycle is either CAS-before-RAS, where both column strobes fall before the row strobe and the memory uses its own row counter, or RAS-only, where the block drives the row address from an internal wrapping counter. The `mode_ras_only` input picks the type, and it is sampled when each cycle starts.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and just after it, `ram_ras_n`, `ram_ucas_n`, `ram_lcas_n` and `ram_we_n` are 1, `bus_req` and `init_done` are 0, and `ram_addr` is 0.
- R2: No strobe moves and `bus_req` stays 0 until the pause has elapsed. With PAUSE_CYC = ceil(PAUSE_NS·CLK_HZ/1e9), `bus_req` first reads 1 after the (PAUSE_CYC+1)-th rising clock edge following reset release.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles run. `init_done` rises only when the last of them completes, stays 1 from then on, and no interval refresh starts before the first interval ends.
- R4: `bus_req` stays 1 from the moment work is owed until the owed burst completes. No strobe moves without a prior `bus_gnt`, and every RAS low time falls inside a `bus_req` high time. With the grant withheld, the strobes stay idle.
- R5: After `init_done`, one refresh is owed every IVL_CYC = floor((RETENTION_NS/2^ROW_BITS)·CLK_HZ/1e9) cycles. With the grant prompt, successive RAS falls are exactly IVL_CYC cycles apart.
- R6: Intervals missed while the grant is withheld accumulate up to MAX_PEND. The burst issued on grant has min(missed, MAX_PEND) cycles.
- R7: When `mode_ras_only` is 0 (CAS-before-RAS), both CAS strobes are low for exactly LEAD_CYC = ceil(LEAD_NS·CLK_HZ/1e9) cycles before RAS falls. They stay low while RAS is low, rise together with RAS, and `ram_addr` is 0.
- R8: When `mode_ras_only` is 1 (RAS-only), both CAS strobes stay 1 while RAS is low, and `ram_addr` carries the row from the cycle before RAS falls through the RAS low time.
- R9: The internal row counter starts at 0 and advances by one after each RAS-only cycle, wrapping from 2^ROW_BITS−1 to 0. CAS-before-RAS cycles leave it unchanged.
- R10: RAS stays low for ACT_CYC = max(ceil(RAS_NS), ceil(TRC_NS)−PRE_CYC−LEAD_CYC) cycles, with PRE_CYC = ceil(TRP_NS) (both in clock cycles). Within a burst, RAS is high for exactly PRE_CYC+LEAD_CYC cycles between RAS low times.
- R11: `ram_we_n` is 1 at every RAS fall and at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ras_only | input | 1 | 1 = RAS-only refresh, 0 = CAS-before-RAS; sampled at cycle start |
| bus_req | output | 1 | Request for the memory pins |
| bus_gnt | input | 1 | Grant from the access arbiter |
| init_done | output | 1 | Power-up pause and wake-up cycles finished |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| ram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low (held high) |
| ram_addr | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
The bench goes after the exact edge on which the pause ends, because an off-by-one timer would request the bus one cycle early or late. It checks that `init_done` comes only after the eighth wake-up cycle, so a design that counted the wrong number of wake-up cycles, or flagged completion at the wrong point, would be seen. It withholds the grant across several intervals, so a design that lost requests, did not saturate, or moved strobes without the grant shows a wrong burst length or an unowned RAS fall. It also walks the row counter past its wrap and interleaves CAS-before-RAS bursts, where a design that advanced the row on the wrong cycle type would present a skipped address.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_ACT, PH_PRE} ref_phase_t;
  typedef enum logic [1:0] {BUS_IDLE, BUS_ASK, BUS_OWN} bus_state_t;

  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

  // Nanoseconds to clock cycles, rounded up, at least one.
  function automatic int unsigned cyc_ceil(input longint unsigned ns,
                                           input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + NS_PER_S - 64'd1) / NS_PER_S;
    return (c == 64'd0) ? 32'd1 : 32'(c);
  endfunction

  // Nanoseconds to clock cycles, rounded down, at least one.
  function automatic int unsigned cyc_floor(input longint unsigned ns,
                                            input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz) / NS_PER_S;
    return (c == 64'd0) ? 32'd1 : 32'(c);
  endfunction

  // RAS low length: the pulse minimum, stretched so lead+low+precharge
  // reaches the full cycle time.
  function automatic int unsigned act_len(input int unsigned ras_c,
                                          input int unsigned trc_c,
                                          input int unsigned pre_c,
                                          input int unsigned lead_c);
    if (trc_c > pre_c + lead_c && trc_c - pre_c - lead_c > ras_c)
      return trc_c - pre_c - lead_c;
    return ras_c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (en)  cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/dref_pend.sv
module dref_pend #(
  parameter int unsigned MAX_PEND = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          take,
  output logic [$clog2(MAX_PEND+1)-1:0] cnt,
  output logic [$clog2(MAX_PEND+1)-1:0] nxt
);
  localparam int unsigned W  = $clog2(MAX_PEND + 1);
  localparam int unsigned W1 = W + 1;

  logic [W1-1:0] sum;

  always_comb begin
    sum = {1'b0, cnt} + W1'(tick) - W1'(take);
    nxt = (sum > W1'(MAX_PEND)) ? W'(MAX_PEND) : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/dref_row.sv
module dref_row #(
  parameter int unsigned ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  output logic [ROW_BITS-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (inc) row <= row + 1'b1;
  end
endmodule

// File: rtl/dref_cycle.sv
module dref_cycle #(
  parameter int unsigned LEAD_CYC = 1,
  parameter int unsigned ACT_CYC  = 2,
  parameter int unsigned PRE_CYC  = 2,
  parameter int unsigned ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                use_row,
  input  logic [ROW_BITS-1:0] row,
  output logic                ras_n,
  output logic                ucas_n,
  output logic                lcas_n,
  output logic [ROW_BITS-1:0] addr,
  output logic                done,
  output logic                mode_q
);
  import dref_pkg::*;

  localparam int unsigned CW = $clog2(max3(LEAD_CYC, ACT_CYC, PRE_CYC) + 1);

  ref_phase_t    phase;
  logic [CW-1:0] cnt;
  logic          strobe_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      phase  <= PH_LEAD;
      cnt    <= CW'(LEAD_CYC - 1);
      mode_q <= use_row;
    end else begin
      unique case (phase)
        PH_LEAD: if (cnt == '0) begin
                   phase <= PH_ACT;
                   cnt   <= CW'(ACT_CYC - 1);
                 end else cnt <= cnt - 1'b1;
        PH_ACT:  if (cnt == '0) begin
                   phase <= PH_PRE;
                   cnt   <= CW'(PRE_CYC - 1);
                 end else cnt <= cnt - 1'b1;
        PH_PRE:  if (cnt == '0) phase <= PH_IDLE;
                 else           cnt   <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign done      = (phase == PH_PRE) && (cnt == '0);
  assign strobe_on = (phase == PH_LEAD) || (phase == PH_ACT);
  assign ras_n     = (phase != PH_ACT);
  assign ucas_n    = !(strobe_on && !mode_q);
  assign lcas_n    = !(strobe_on && !mode_q);
  assign addr      = (mode_q && phase != PH_IDLE) ? row : '0;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter longint unsigned CLK_HZ       = 50_000_000,
  parameter longint unsigned PAUSE_NS     = 200_000,
  parameter int unsigned     WAKE_CYCLES  = 8,
  parameter int unsigned     ROW_BITS     = 9,
  parameter longint unsigned RETENTION_NS = 8_000_000,
  parameter longint unsigned LEAD_NS      = 10,
  parameter longint unsigned RAS_NS       = 35,
  parameter longint unsigned TRP_NS       = 25,
  parameter longint unsigned TRC_NS       = 60,
  parameter int unsigned     MAX_PEND     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_ras_only,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                init_done,
  output logic                ram_ras_n,
  output logic                ram_ucas_n,
  output logic                ram_lcas_n,
  output logic                ram_we_n,
  output logic [ROW_BITS-1:0] ram_addr
);
  import dref_pkg::*;

  localparam longint unsigned ROWS = 64'd1 << ROW_BITS;
  localparam int unsigned PAUSE_CYC = cyc_ceil(PAUSE_NS, CLK_HZ);
  localparam int unsigned IVL_CYC   = cyc_floor(RETENTION_NS / ROWS, CLK_HZ);
  localparam int unsigned LEAD_CYC  = cyc_ceil(LEAD_NS, CLK_HZ);
  localparam int unsigned PRE_CYC   = cyc_ceil(TRP_NS, CLK_HZ);
  localparam int unsigned ACT_CYC   = act_len(cyc_ceil(RAS_NS, CLK_HZ),
                                              cyc_ceil(TRC_NS, CLK_HZ),
                                              PRE_CYC, LEAD_CYC);
  localparam int unsigned WW = $clog2(WAKE_CYCLES + 1);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  // Named internal events, observed by the bound checker.
  logic                pause_done;
  logic                pause_tick;
  logic                ivl_tick;
  logic                ev_cyc_done;
  logic                ev_ras_fall;
  logic                cyc_mode;
  logic                cyc_start;
  logic [ROW_BITS-1:0] row_q;
  logic [PW-1:0]       pend_cnt;
  logic [PW-1:0]       pend_nxt;
  logic [WW-1:0]       wake_left;
  logic                wake_busy;
  logic                take_wake;
  logic                take_pend;
  logic                owe_now;
  logic                owe_after;
  logic                ras_prev;
  bus_state_t          st, st_nxt;

  // Power-up pause: one-shot use of the interval timer.
  dref_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(!pause_done), .tick(pause_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pause_done <= 1'b0;
    else        pause_done <= pause_done | pause_tick;
  end

  // Refresh interval timer, running once initialization is over.
  dref_timer #(.LIMIT(IVL_CYC)) u_ivl (
    .clk(clk), .rst_n(rst_n), .en(init_done), .tick(ivl_tick)
  );

  assign wake_busy = (wake_left != '0);
  assign take_wake = ev_cyc_done && wake_busy;
  assign take_pend = ev_cyc_done && !wake_busy;

  dref_pend #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(ivl_tick), .take(take_pend),
    .cnt(pend_cnt), .nxt(pend_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_left <= WW'(WAKE_CYCLES);
      init_done <= 1'b0;
    end else if (take_wake) begin
      wake_left <= wake_left - 1'b1;
      if (wake_left == WW'(1)) init_done <= 1'b1;
    end
  end

  assign owe_now   = pause_done && (wake_busy || pend_cnt != '0);
  assign owe_after = (wake_busy && wake_left != WW'(1)) || (pend_nxt != '0);

  // Bus ownership: ask, wait for grant, keep the bus for the whole burst.
  always_comb begin
    st_nxt    = st;
    cyc_start = 1'b0;
    unique case (st)
      BUS_IDLE: if (owe_now) st_nxt = BUS_ASK;
      BUS_ASK:  if (bus_gnt) begin
                  st_nxt    = BUS_OWN;
                  cyc_start = 1'b1;
                end
      BUS_OWN:  if (ev_cyc_done) begin
                  if (owe_after) cyc_start = 1'b1;
                  else           st_nxt    = BUS_IDLE;
                end
      default:  st_nxt = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= BUS_IDLE;
    else        st <= st_nxt;
  end

  assign bus_req = (st != BUS_IDLE);

  dref_row #(.ROW_BITS(ROW_BITS)) u_row (
    .clk(clk), .rst_n(rst_n), .inc(ev_cyc_done && cyc_mode), .row(row_q)
  );

  dref_cycle #(
    .LEAD_CYC(LEAD_CYC), .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC),
    .ROW_BITS(ROW_BITS)
  ) u_cycle (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .use_row(mode_ras_only),
    .row(row_q), .ras_n(ram_ras_n), .ucas_n(ram_ucas_n),
    .lcas_n(ram_lcas_n), .addr(ram_addr), .done(ev_cyc_done),
    .mode_q(cyc_mode)
  );

  assign ram_we_n = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ras_prev <= 1'b1;
    else        ras_prev <= ram_ras_n;
  end

  assign ev_ras_fall = ras_prev && !ram_ras_n;
endmodule

// File: rtl/dref_chk.sv
module dref_chk #(
  parameter int unsigned ROW_BITS = 9,
  parameter int unsigned MAX_PEND = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          pause_done,
  input logic                          init_done,
  input logic                          bus_req,
  input logic                          ev_cyc_done,
  input logic                          ev_ras_fall,
  input logic                          cyc_mode,
  input logic [ROW_BITS-1:0]           row_q,
  input logic [$clog2(MAX_PEND+1)-1:0] pend_cnt,
  input logic                          ram_ras_n,
  input logic                          ram_ucas_n,
  input logic                          ram_lcas_n
);
  // R2
  quiet_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (ram_ras_n && ram_ucas_n && ram_lcas_n && !bus_req));

  // R3
  init_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(ev_cyc_done));

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R4
  strobe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (ram_ras_n && ram_ucas_n && ram_lcas_n));

  // R6
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= ($clog2(MAX_PEND+1))'(MAX_PEND));

  // R7
  cbr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ras_fall && !cyc_mode) |-> $past(!ram_ucas_n && !ram_lcas_n));

  // R8
  rasonly_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ras_n && cyc_mode) |-> (ram_ucas_n && ram_lcas_n));

  // R9
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cyc_done && cyc_mode) |=> (row_q == ROW_BITS'($past(row_q) + 1'b1)));

  // R9
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cyc_done && !cyc_mode) |=> $stable(row_q));

  // R10
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_ras_n) |=> ram_ras_n);
endmodule

bind dram_refresh_seq dref_chk #(.ROW_BITS(ROW_BITS), .MAX_PEND(MAX_PEND)) u_chk (
  .clk(clk), .rst_n(rst_n), .pause_done(pause_done), .init_done(init_done),
  .bus_req(bus_req), .ev_cyc_done(ev_cyc_done), .ev_ras_fall(ev_ras_fall),
  .cyc_mode(cyc_mode), .row_q(row_q), .pend_cnt(pend_cnt),
  .ram_ras_n(ram_ras_n), .ram_ucas_n(ram_ucas_n), .ram_lcas_n(ram_lcas_n)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
  // Small configuration, 50 MHz: one cycle = 20 ns.
  localparam int T_NS     = 20;
  localparam int ROWB     = 4;
  localparam int ROWS_E   = 16;
  localparam int PAUSE_E  = (2000 + T_NS - 1) / T_NS;     // 100
  localparam int IVL_E    = (32000 / ROWS_E) / T_NS;      // 100
  localparam int LEAD_E   = (10 + T_NS - 1) / T_NS;       // 1
  localparam int PRE_E    = (25 + T_NS - 1) / T_NS;       // 2
  localparam int RASC_E   = (35 + T_NS - 1) / T_NS;       // 2
  localparam int TRC_E    = (150 + T_NS - 1) / T_NS;      // 8
  localparam int ACT_E    = (TRC_E - PRE_E - LEAD_E > RASC_E) ?
                            TRC_E - PRE_E - LEAD_E : RASC_E; // 5
  localparam int WAKE_E   = 8;
  localparam int MAXP_E   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ras_only = 1'b0;
  logic bus_gnt = 1'b0;
  logic hold = 1'b0;
  logic bus_req, init_done, ram_ras_n, ram_ucas_n, ram_lcas_n, ram_we_n;
  logic [ROWB-1:0] ram_addr;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .CLK_HZ(50_000_000), .PAUSE_NS(2000), .WAKE_CYCLES(WAKE_E),
    .ROW_BITS(ROWB), .RETENTION_NS(32000), .LEAD_NS(10), .RAS_NS(35),
    .TRP_NS(25), .TRC_NS(150), .MAX_PEND(MAXP_E)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_ras_only),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .init_done(init_done),
    .ram_ras_n(ram_ras_n), .ram_ucas_n(ram_ucas_n), .ram_lcas_n(ram_lcas_n),
    .ram_we_n(ram_we_n), .ram_addr(ram_addr)
  );

  // Arbiter model: grants one cycle after a request unless held off.
  always @(posedge clk) bus_gnt <= bus_req && !hold;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int falls = 0;
  int last_fall = 0;
  int last_gap = 0;
  int exp_row = 0;
  int lo_run = 0, hi_run = 0, cas_run = 0;
  logic ras_prev_s = 1'b1;
  logic [ROWB-1:0] addr_prev = '0;
  int tph = 0, tnum = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Interval phase tracker: counts cycles since init_done went high.
  always @(posedge clk) begin
    if (init_done) begin
      if (tph == IVL_E - 1) begin tph <= 0; tnum <= tnum + 1; end
      else tph <= tph + 1;
    end
  end

  // Pin monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_prev_s && !ram_ras_n) begin
        falls++;
        last_fall = cyc;
        last_gap = hi_run;
        chk(ram_we_n === 1'b1, "R11", "WE at RAS fall", ram_we_n, 1);
        chk(bus_req === 1'b1, "R4", "bus owned at RAS fall", bus_req, 1);
        chk(hi_run >= PRE_E + LEAD_E, "R10", "RAS high gap", hi_run, PRE_E + LEAD_E);
        if (!mode_ras_only) begin
          chk(!ram_ucas_n && !ram_lcas_n, "R7", "CAS low with RAS", ram_ucas_n, 0);
          chk(cas_run == LEAD_E, "R7", "CAS lead cycles", cas_run, LEAD_E);
          chk(ram_addr == '0, "R7", "address in CBR", ram_addr, 0);
        end else begin
          chk(ram_ucas_n && ram_lcas_n, "R8", "CAS high in RAS-only", ram_ucas_n, 1);
          chk(ram_addr == addr_prev, "R8", "address setup", addr_prev, ram_addr);
          chk(int'(ram_addr) == exp_row, "R9", "row address", ram_addr, exp_row);
          exp_row = (exp_row + 1) % ROWS_E;
        end
      end
      if (!ras_prev_s && ram_ras_n) begin
        chk(lo_run == ACT_E, "R10", "RAS low width", lo_run, ACT_E);
        if (!mode_ras_only)
          chk(ram_ucas_n && ram_lcas_n, "R7", "CAS rises with RAS", ram_ucas_n, 1);
      end
      lo_run  = ram_ras_n ? 0 : lo_run + 1;
      hi_run  = ram_ras_n ? hi_run + 1 : 0;
      cas_run = ram_ucas_n ? 0 : cas_run + 1;
      ras_prev_s = ram_ras_n;
      addr_prev  = ram_addr;
    end
  end

  task automatic wait_mid(input int n);
    int target;
    target = tnum + n;
    @(negedge clk);
    while (!(tnum == target && tph == IVL_E / 2)) @(negedge clk);
  endtask

  task automatic single(input bit spaced);
    int f0, t_prev;
    f0 = falls;
    t_prev = last_fall;
    wait_mid(1);
    chk(falls == f0 + 1, "R5", "one refresh per interval", falls - f0, 1);
    if (spaced)
      chk(last_fall - t_prev == IVL_E, "R5", "refresh spacing", last_fall - t_prev, IVL_E);
  endtask

  task automatic burst(input int n);
    int f0, exp_n;
    exp_n = (n < MAXP_E) ? n : MAXP_E;
    f0 = falls;
    hold = 1'b1;
    wait_mid(n);
    chk(bus_req === 1'b1, "R4", "request held without grant", bus_req, 1);
    chk(falls == f0 && ram_ras_n && ram_ucas_n, "R4", "no strobes before grant", falls - f0, 0);
    hold = 1'b0;
    while (bus_req) @(negedge clk);
    chk(falls - f0 == exp_n, "R6", "burst length", falls - f0, exp_n);
    if (exp_n >= 2)
      chk(last_gap == PRE_E + LEAD_E, "R10", "burst gap", last_gap, PRE_E + LEAD_E);
  endtask

  task automatic run_all();
    int edges;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ram_ras_n && ram_ucas_n && ram_lcas_n && ram_we_n, "R1", "strobes in reset", ram_ras_n, 1);
    chk(!bus_req && !init_done, "R1", "req/done in reset", bus_req, 0);
    chk(ram_addr == '0, "R1", "address in reset", ram_addr, 0);
    rst_n = 1'b1;
    // R2: pause length
    edges = 0;
    do begin
      @(posedge clk); edges++;
      @(negedge clk);
    end while (!bus_req && edges < 10 * PAUSE_E);
    chk(edges == PAUSE_E + 1, "R2", "edges until first request", edges, PAUSE_E + 1);
    chk(falls == 0, "R2", "no RAS during pause", falls, 0);
    // R3: wake-up cycles
    while (!init_done) @(negedge clk);
    chk(falls == WAKE_E, "R3", "wake-up cycles at init_done", falls, WAKE_E);
    wait_mid(0);
    chk(falls == WAKE_E, "R3", "no refresh before first interval", falls, WAKE_E);
    // R5/R7: CBR singles
    single(1'b0);
    single(1'b1);
    single(1'b1);
    // R5/R8/R9: RAS-only singles across the row wrap
    mode_ras_only = 1'b1;
    for (int i = 0; i < 20; i++) single(1'b1);
    chk(exp_row == 20 % ROWS_E, "R9", "rows used after wrap", exp_row, 20 % ROWS_E);
    // R4/R6: withheld grants
    burst(2);
    burst(5);
    mode_ras_only = 1'b0;
    burst(3);
    burst(1);
    // R9: CBR left the row counter alone
    mode_ras_only = 1'b1;
    single(1'b0);
    single(1'b1);
    chk(exp_row == 27 % ROWS_E, "R9", "row after CBR bursts", exp_row, 27 % ROWS_E);
    chk(init_done === 1'b1, "R3", "init_done stays high", init_done, 1);
    chk(ram_we_n === 1'b1, "R11", "WE idle level", ram_we_n, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule